// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block handles the acknowledge and return side of the interrupt system in a small 8-bit controller core. Six sources present pending request flags: two external inputs, two timers, the serial port and a third timer. Each source is assigned to one of two priority levels. Whenever the core reports that an instruction has completed, the block picks at most one eligible request. It then raises a one-cycle strobe that tells the core to push the program counter, and it presents the 16-bit vector address of the chosen source. Only the program counter is pushed. The status word is not saved.

On acknowledge, the block also returns a one-cycle hardware-clear strobe to each source whose flag the hardware is allowed to clear. The two timer overflow flags are always cleared. An external flag is cleared only when its input is in transition mode. The serial and third-timer flags are never cleared, and software must clear them. The block keeps a two-bit in-service stack, with one bit per level. Only the return-from-interrupt strobe pops this stack. A plain subroutine return strobe leaves it unchanged.

Top module: `vec_irq_ack`

## Requirements
- R1: After reset, ack_stb is 0, vec_addr is 16'h0000, clr_stb is 0, ack_src is 0, ack_hi is 0 and in_service is 2'b00.
- R2: ack_stb is high in a cycle exactly when, at the previous clock edge, instr_done was 1 and at least one eligible request was pending. A request is eligible when its req_flags bit is 1 and its level is not blocked (see R9).
- R3: Source index i uses these bit positions: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2. On acknowledge of source i, vec_addr becomes 16'h0003 + 8*i, which gives 0003, 000B, 0013, 001B, 0023 and 002B. ack_src becomes i, and ack_hi shows the level of that source.
- R4: When several eligible requests share the winning level, the lowest source index wins.
- R5: When eligible requests exist on both levels, a high-level request (its hi_level bit is 1) wins over any low-level one.
- R6: Acknowledging timer 0 (index 1) or timer 1 (index 3) pulses clr_stb for that index in the same cycle as ack_stb.
- R7: Acknowledging serial (index 4) or timer 2 (index 5) never asserts any clr_stb bit.
- R8: Acknowledging external 0 (index 0) or external 1 (index 2) pulses that clr_stb bit only when ext_edge bit 0 (for external 0) or bit 1 (for external 1) is 1. When that bit is 0, meaning level mode, no clr_stb bit is asserted.
- R9: in_service bit 0 marks a low-level routine and bit 1 marks a high-level routine. An acknowledge sets the bit of its level. Low-level requests are blocked while either bit is set. High-level requests are blocked only while bit 1 is set, so a high-level request can preempt a low-level routine.
- R10: reti_stb clears the highest set bit of in_service as it was before the clock edge. It acts one cycle later, and any acknowledge in the same cycle then sets its own bit.
- R11: ret_stb alone has no effect on in_service, ack_stb or clr_stb.
- R12: vec_addr, ack_src and ack_hi hold their last values in cycles without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction completes this cycle |
| req_flags | input | 6 | Pending request flags by source index |
| hi_level | input | 6 | 1 places the source on the high level |
| ext_edge | input | 2 | Transition mode for external 0 and external 1 |
| reti_stb | input | 1 | Return-from-interrupt executed |
| ret_stb | input | 1 | Plain subroutine return executed |
| ack_stb | output | 1 | Push program counter and jump to vector |
| vec_addr | output | 16 | Vector address of the last acknowledge |
| clr_stb | output | 6 | Hardware flag-clear strobes by source |
| ack_src | output | 3 | Index of the last acknowledged source |
| ack_hi | output | 1 | Level of the last acknowledged source |
| in_service | output | 2 | In-service stack, bit 1 high level |

## Verification
Every result is registered once. The acknowledge strobe, vector, source, level, clear strobes and in-service update all appear one clock edge after the inputs that cause them, and the return strobes act on the same edge. The bench drives inputs on the falling edge. It checks the outputs on the next falling edge against a model updated for exactly that one edge, so each comparison lands in the cycle the result is due. Random traffic with mixed levels, modes and return strobes is combined with directed sequences for preemption, plain return and priority order.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int unsigned NSRC       = 6;
  localparam int unsigned SRC_W      = $clog2(NSRC);
  localparam int unsigned VEC_W      = 16;
  localparam int unsigned VEC_BASE   = 3;
  localparam int unsigned VEC_STRIDE = 8;
  localparam int unsigned NLVL       = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  typedef struct packed {
    logic             valid;
    logic             hi;
    logic [SRC_W-1:0] idx;
  } pick_t;

  // vector address of a source: base plus a fixed stride per index
  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
    return VEC_W'(VEC_BASE) + (VEC_W'(idx) * VEC_W'(VEC_STRIDE));
  endfunction

  // whether hardware may clear the source flag on acknowledge
  function automatic logic hw_clears(input logic [SRC_W-1:0] idx,
                                     input logic [1:0] edge_mode);
    case (idx)
      SRC_TMR0, SRC_TMR1: return 1'b1;
      SRC_EXT0:           return edge_mode[0];
      SRC_EXT1:           return edge_mode[1];
      default:            return 1'b0;
    endcase
  endfunction

  // lowest set bit index of a request vector
  function automatic logic [SRC_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = SRC_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ack_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] hi_lvl,
  input  logic [1:0]   in_svc,
  output pick_t        pick
);
  logic         hi_open;
  logic         lo_open;
  logic [N-1:0] elig_hi;
  logic [N-1:0] elig_lo;

  assign hi_open = !in_svc[1];
  assign lo_open = (in_svc == 2'b00);
  assign elig_hi = req &  hi_lvl & {N{hi_open}};
  assign elig_lo = req & ~hi_lvl & {N{lo_open}};

  always_comb begin
    pick = '0;
    if (|elig_hi) begin
      pick.valid = 1'b1;
      pick.hi    = 1'b1;
      pick.idx   = first_set(elig_hi);
    end else if (|elig_lo) begin
      pick.valid = 1'b1;
      pick.hi    = 1'b0;
      pick.idx   = first_set(elig_lo);
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       push_hi,
  input  logic       pop,
  input  logic       plain_ret,
  output logic [1:0] in_svc
);
  logic [1:0] pop_mask;
  logic [1:0] push_mask;
  logic [1:0] svc_q;

  assign pop_mask  = !pop ? 2'b00 : (svc_q[1] ? 2'b10 : 2'b01);
  assign push_mask = !push ? 2'b00 : (push_hi ? 2'b10 : 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= 2'b00;
    else        svc_q <= (svc_q & ~pop_mask) | push_mask;
  end

  assign in_svc = svc_q;

  AST_RET_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_ret && !pop && !push) |=> $stable(in_svc)); // R11

  AST_RETI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && in_svc != 2'b00) |=> ($countones(in_svc) + 1 == $countones($past(in_svc)))); // R10

  AST_HI_POP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && in_svc == 2'b11) |=> (in_svc == 2'b01)); // R10
endmodule

// File: rtl/vec_irq_ack.sv
module vec_irq_ack
  import irq_ack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_done,
  input  logic [NSRC-1:0]  req_flags,
  input  logic [NSRC-1:0]  hi_level,
  input  logic [1:0]       ext_edge,
  input  logic             reti_stb,
  input  logic             ret_stb,
  output logic             ack_stb,
  output logic [VEC_W-1:0] vec_addr,
  output logic [NSRC-1:0]  clr_stb,
  output logic [SRC_W-1:0] ack_src,
  output logic             ack_hi,
  output logic [1:0]       in_service
);
  pick_t           pick;
  logic            ack_fire;
  logic [NSRC-1:0] clr_next;

  irq_pick #(.N(NSRC)) u_pick (
    .req    (req_flags),
    .hi_lvl (hi_level),
    .in_svc (in_service),
    .pick   (pick)
  );

  assign ack_fire = instr_done && pick.valid;

  for (genvar g = 0; g < NSRC; g++) begin : g_clr
    assign clr_next[g] = ack_fire && (pick.idx == SRC_W'(g))
                         && hw_clears(SRC_W'(g), ext_edge);
  end

  irq_svc_stack u_svc (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_fire),
    .push_hi   (pick.hi),
    .pop       (reti_stb),
    .plain_ret (ret_stb),
    .in_svc    (in_service)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_stb  <= 1'b0;
      vec_addr <= '0;
      clr_stb  <= '0;
      ack_src  <= '0;
      ack_hi   <= 1'b0;
    end else begin
      ack_stb <= ack_fire;
      clr_stb <= clr_next;
      if (ack_fire) begin
        vec_addr <= vec_of(pick.idx);
        ack_src  <= pick.idx;
        ack_hi   <= pick.hi;
      end
    end
  end

  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> $past(instr_done)); // R2

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> (vec_addr[2:0] == 3'b011 && vec_addr[VEC_W-1:6] == '0)); // R3

  AST_CLR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb != '0) |-> (ack_stb && $onehot0(clr_stb))); // R6

  AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service[1] && !reti_stb) |=> !ack_stb); // R9

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire |=> $stable(vec_addr)); // R12
endmodule

// File: tb/test_vec_irq_ack.sv
module test_vec_irq_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0;
  logic [5:0]  req_flags = '0;
  logic [5:0]  hi_level = '0;
  logic [1:0]  ext_edge = '0;
  logic        reti_stb = 1'b0;
  logic        ret_stb = 1'b0;
  logic        ack_stb;
  logic [15:0] vec_addr;
  logic [5:0]  clr_stb;
  logic [2:0]  ack_src;
  logic        ack_hi;
  logic [1:0]  in_service;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // model state and expectations
  logic [1:0]  m_svc = 2'b00;
  logic        e_ack = 1'b0;
  logic [15:0] e_vec = 16'h0000;
  logic [5:0]  e_clr = '0;
  logic [2:0]  e_src = '0;
  logic        e_hi = 1'b0;
  string       tag_src = "R4";
  string       tag_clr = "R7";
  string       tag_svc = "R9";
  string       tag_vec = "R12";

  always #10 clk = ~clk;

  vec_irq_ack i_vec_irq_ack (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .req_flags(req_flags),
    .hi_level(hi_level), .ext_edge(ext_edge), .reti_stb(reti_stb), .ret_stb(ret_stb),
    .ack_stb(ack_stb), .vec_addr(vec_addr), .clr_stb(clr_stb), .ack_src(ack_src),
    .ack_hi(ack_hi), .in_service(in_service)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] vec_table(input int i);
    case (i)
      0: return 16'h0003; 1: return 16'h000B; 2: return 16'h0013;
      3: return 16'h001B; 4: return 16'h0023; default: return 16'h002B;
    endcase
  endfunction

  function automatic bit clears(input int i, input logic [1:0] em);
    if (i == 1 || i == 3) return 1'b1;
    if (i == 0) return em[0];
    if (i == 2) return em[1];
    return 1'b0;
  endfunction

  task automatic compare_all();
    chk("R2", "ack_stb", int'(ack_stb), int'(e_ack));
    chk(tag_vec, "vec_addr", int'(vec_addr), int'(e_vec));
    chk(tag_src, "ack_src", int'(ack_src), int'(e_src));
    chk(tag_src, "ack_hi", int'(ack_hi), int'(e_hi));
    chk(tag_clr, "clr_stb", int'(clr_stb), int'(e_clr));
    chk(tag_svc, "in_service", int'(in_service), int'(m_svc));
  endtask

  // drive one cycle at the falling edge and check it on the next one
  task automatic step(input bit d, input logic [5:0] rq, input logic [5:0] hl,
                      input logic [1:0] em, input bit rt, input bit pr);
    int  best;
    int  lv;
    bit  both;
    logic [1:0] ns;
    instr_done = d; req_flags = rq; hi_level = hl; ext_edge = em;
    reti_stb = rt; ret_stb = pr;
    best = -1; lv = 0;
    if (!m_svc[1]) begin
      for (int i = 0; i < 6; i++) if (best < 0 && rq[i] && hl[i]) begin best = i; lv = 1; end
    end
    if (best < 0 && m_svc == 2'b00) begin
      for (int i = 0; i < 6; i++) if (best < 0 && rq[i] && !hl[i]) begin best = i; lv = 0; end
    end
    both = (m_svc == 2'b00) && |(rq & hl) && |(rq & ~hl);
    e_ack = d && best >= 0;
    e_clr = '0;
    tag_vec = "R12";
    tag_src = "R12";
    tag_clr = pr ? "R11" : "R2";
    if (e_ack) begin
      e_vec = vec_table(best);
      e_src = 3'(best);
      e_hi = lv[0];
      tag_vec = "R3";
      tag_src = both ? "R5" : "R4";
      if (clears(best, em)) e_clr[best] = 1'b1;
      tag_clr = (best == 1 || best == 3) ? "R6" : (best >= 4 ? "R7" : "R8");
    end
    ns = m_svc;
    if (rt) begin
      if (ns[1]) ns[1] = 1'b0; else ns[0] = 1'b0;
    end
    if (e_ack) ns[lv] = 1'b1;
    tag_svc = rt ? "R10" : (pr ? "R11" : "R9");
    @(negedge clk);
    m_svc = ns;
    compare_all();
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd7411);
    repeat (3) @(negedge clk);
    tag_vec = "R1"; tag_src = "R1"; tag_clr = "R1"; tag_svc = "R1";
    compare_all();
    chk("R1", "ack_stb reset", int'(ack_stb), 0);
    rst_n = 1'b1;
    // directed: all low-level, ext0 level mode wins, no clear
    step(1, 6'b111111, 6'b000000, 2'b00, 0, 0);
    // blocked low while in service; plain return keeps state
    step(1, 6'b111110, 6'b000000, 2'b00, 0, 1);
    // high-level timer 2 preempts low routine
    step(1, 6'b100000, 6'b100000, 2'b00, 0, 0);
    // nothing preempts high
    step(1, 6'b111111, 6'b111111, 2'b11, 0, 0);
    // return pops high first, then low
    step(0, 6'b000000, 6'b000000, 2'b00, 1, 0);
    step(0, 6'b000000, 6'b000000, 2'b00, 1, 0);
    // ext1 edge mode clears; instr_done low delays ack
    step(0, 6'b000100, 6'b000000, 2'b10, 0, 0);
    step(1, 6'b000100, 6'b000000, 2'b10, 0, 0);
    step(0, 6'b000000, 6'b000000, 2'b00, 1, 0);
    // high level beats lower index on low level
    step(1, 6'b001001, 6'b001000, 2'b01, 0, 0);
    step(0, 6'b000000, 6'b000000, 2'b00, 1, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] rq;
      rq = 6'($urandom) & 6'($urandom);
      step(($urandom % 10) < 7, rq, 6'($urandom), 2'($urandom),
           ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule